// File: doc/BRIEF.md
# Subtrain-Slotted Pixel Hit Timestamp Buffer

This block records when pixels fire during one bunch train. A single shared crossing counter, started by a train-start pulse, counts bunch crossings across the train. The top bits of that count name the current subtrain. Every pixel owns exactly one storage slot per subtrain. When a pixel's above-threshold hit input is high during a crossing, the crossing count is written into that pixel's slot for the current subtrain.

No pixel keeps a fill counter of its own. Slot selection comes entirely from the shared subtrain index. A pixel therefore overflows only when two hits land in the same subtrain. If a slot is already filled, the first timestamp is kept and a sticky overflow bit is raised for that slot.

Once the train has ended, a scan port reads the slots back one at a time. The port takes a pixel address and a subtrain address and returns the slot's valid bit, overflow bit and timestamp one clock later.

Top module: `hit_ts_buffer`

## Requirements
- R1: After synchronous reset, `train_active` is 0, `rd_vld` is 0, and every slot of every pixel reads back with valid 0 and overflow 0.
- R2: A `train_start` pulse clears every valid and overflow bit and sets the crossing count to 0. `train_active` is 1 after that edge, and crossing 0 is the first cycle after the pulse. A hit in the same cycle as the pulse is not recorded.
- R3: While the train is active, the crossing count rises by one per cycle. `train_active` stays 1 through crossing TRAIN_XINGS-1 and drops at the edge that ends that crossing.
- R4: The subtrain index is the top SUB_W bits of the TS_W-bit crossing count, so a subtrain spans 2^(TS_W-SUB_W) crossings. The first accepted hit in a slot sets its valid bit and stores the crossing count as the timestamp.
- R5: A second or later hit in a slot that is already valid leaves the stored timestamp unchanged and sets the slot's overflow bit. That bit stays set until the next `train_start`.
- R6: Hits on several pixels in the same cycle are all recorded, each in that pixel's own slot.
- R7: Hits while `train_active` is 0, whether before the start pulse or after the last crossing, change no slot.
- R8: When `rd_en` is high at an edge with address (`rd_pix`, `rd_sub`), the next cycle shows `rd_vld`=1 together with that slot's valid bit, overflow bit and timestamp. An edge with `rd_en` low gives `rd_vld`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one bunch crossing per cycle while active |
| rst | input | 1 | Synchronous active-high reset |
| train_start | input | 1 | Single-cycle pulse that opens a train |
| hit | input | NUM_PIX | Above-threshold hit, one bit per pixel |
| train_active | output | 1 | High while crossings of the train are counted |
| rd_en | input | 1 | Read request for one slot |
| rd_pix | input | PIX_AW | Pixel address of the read |
| rd_sub | input | SUB_W | Subtrain address of the read |
| rd_vld | output | 1 | Read data present this cycle |
| rd_slot_valid | output | 1 | Slot holds a timestamp |
| rd_ovf | output | 1 | Slot saw more than one hit |
| rd_ts | output | TS_W | Stored crossing timestamp |

## Verification
Assertions check several things on every cycle. The crossing count steps by one while the train is active, and the train closes after its final crossing. A valid slot's timestamp never changes before the next start. Overflow bits are sticky and appear only on valid slots. Inactive cycles leave slot state untouched. The read strobe follows the request by one cycle. Only the bench's scenarios can show the exact timestamp values per subtrain, including the partial last subtrain and the hit discarded during the start pulse. They also show that simultaneous hits on different pixels are recorded independently, and that a new train wipes the overflow state of the previous one.

// File: rtl/hbuf_pkg.sv
package hbuf_pkg;

    // Default geometry: 14-bit crossing count, 16 subtrains, 4 pixels.
    localparam int unsigned DEF_TS_W        = 14;
    localparam int unsigned DEF_SUB_W       = 4;
    localparam int unsigned DEF_NUM_PIX     = 4;
    localparam int unsigned DEF_TRAIN_XINGS = 16384;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_t;

    typedef struct packed {
        logic valid;
        logic ovf;
    } slot_flags_t;

    // Subtrain index: the upper sub_w bits of a ts_w-bit crossing count.
    function automatic logic [31:0] subtrain_of(input logic [31:0] xing,
                                                input int unsigned ts_w,
                                                input int unsigned sub_w);
        return xing >> (ts_w - sub_w);
    endfunction

endpackage

// File: rtl/hbuf_xing_ctr.sv
module hbuf_xing_ctr
    import hbuf_pkg::*;
#(
    parameter int unsigned TS_W        = DEF_TS_W,
    parameter int unsigned SUB_W       = DEF_SUB_W,
    parameter int unsigned TRAIN_XINGS = DEF_TRAIN_XINGS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             active,
    output logic [TS_W-1:0]  stamp,
    output logic [SUB_W-1:0] sub_idx
);

    localparam logic [TS_W-1:0] LAST_X = TS_W'(TRAIN_XINGS - 1);

    phase_t          phase_q;
    logic [TS_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            count_q <= '0;
        end else if (start) begin
            phase_q <= PH_RUN;
            count_q <= '0;
        end else if (phase_q == PH_RUN) begin
            if (count_q == LAST_X) begin
                phase_q <= PH_IDLE;
            end else begin
                count_q <= count_q + 1'b1;
            end
        end
    end

    assign active  = (phase_q == PH_RUN);
    assign stamp   = count_q;
    assign sub_idx = SUB_W'(subtrain_of(32'(count_q), TS_W, SUB_W));

    // R2: a start pulse opens the train at crossing zero
    assert_start_zero_R2: assert property (@(posedge clk) disable iff (rst)
        start |=> (active && stamp == '0));

    // R3: one crossing per cycle inside the train
    assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
        (active && !start && stamp != LAST_X) |=> (active && stamp == $past(stamp) + 1'b1));

    // R3: the train closes after its final crossing
    assert_train_close_R3: assert property (@(posedge clk) disable iff (rst)
        (active && !start && stamp == LAST_X) |=> !active);

endmodule

// File: rtl/hbuf_pixel.sv
module hbuf_pixel
    import hbuf_pkg::*;
#(
    parameter int unsigned TS_W  = DEF_TS_W,
    parameter int unsigned SUB_W = DEF_SUB_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             accept,
    input  logic [SUB_W-1:0] sub_idx,
    input  logic [TS_W-1:0]  stamp,
    input  logic [SUB_W-1:0] rd_sub,
    output slot_flags_t      rd_flags,
    output logic [TS_W-1:0]  rd_ts
);

    localparam int unsigned N_SUB = 1 << SUB_W;

    logic [N_SUB-1:0] valid_q;
    logic [N_SUB-1:0] ovf_q;
    logic [TS_W-1:0]  ts_mem [N_SUB];

    logic first_hit;
    assign first_hit = accept && !valid_q[sub_idx];

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            valid_q <= '0;
            ovf_q   <= '0;
        end else if (accept) begin
            if (valid_q[sub_idx]) begin
                ovf_q[sub_idx] <= 1'b1;
            end else begin
                valid_q[sub_idx] <= 1'b1;
            end
        end
    end

    // Timestamp storage carries no reset; valid bits qualify it.
    always_ff @(posedge clk) begin
        if (!rst && !clear && first_hit) begin
            ts_mem[sub_idx] <= stamp;
        end
    end

    assign rd_flags.valid = valid_q[rd_sub];
    assign rd_flags.ovf   = ovf_q[rd_sub];
    assign rd_ts          = ts_mem[rd_sub];

    // R7: cycles without an accepted hit or clear leave slot state alone
    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!accept && !clear) |=> ($stable(valid_q) && $stable(ovf_q)));

    generate
        for (genvar s = 0; s < N_SUB; s++) begin : g_slot_chk
            // R5: the first timestamp survives later hits
            assert_keep_first_R5: assert property (@(posedge clk) disable iff (rst)
                (valid_q[s] && !clear) |=> $stable(ts_mem[s]));
            // R5: overflow is sticky within a train
            assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (rst)
                (ovf_q[s] && !clear) |=> ovf_q[s]);
            // R5: overflow only on a filled slot
            assert_ovf_on_valid_R5: assert property (@(posedge clk) disable iff (rst)
                ovf_q[s] |-> valid_q[s]);
        end
    endgenerate

endmodule

// File: rtl/hbuf_readout.sv
module hbuf_readout
    import hbuf_pkg::*;
#(
    parameter int unsigned TS_W    = DEF_TS_W,
    parameter int unsigned NUM_PIX = DEF_NUM_PIX,
    parameter int unsigned PIX_AW  = (NUM_PIX > 1) ? $clog2(NUM_PIX) : 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          rd_en,
    input  logic [PIX_AW-1:0]             rd_pix,
    input  slot_flags_t [NUM_PIX-1:0]     pix_flags,
    input  logic [NUM_PIX-1:0][TS_W-1:0]  pix_ts,
    output logic                          rd_vld,
    output slot_flags_t                   rd_flags,
    output logic [TS_W-1:0]               rd_ts
);

    slot_flags_t     sel_flags;
    logic [TS_W-1:0] sel_ts;

    always_comb begin
        sel_flags = '0;
        sel_ts    = '0;
        for (int p = 0; p < NUM_PIX; p++) begin
            if (32'(rd_pix) == 32'(p)) begin
                sel_flags = pix_flags[p];
                sel_ts    = pix_ts[p];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_vld   <= 1'b0;
            rd_flags <= '0;
            rd_ts    <= '0;
        end else begin
            rd_vld <= rd_en;
            if (rd_en) begin
                rd_flags <= sel_flags;
                rd_ts    <= sel_ts;
            end
        end
    end

    // R8: read data strobe follows the request by one cycle
    assert_rd_latency_R8: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_vld);
    assert_rd_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_vld);
    // R5: returned overflow always accompanies a filled slot
    assert_rd_ovf_valid_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_vld && rd_flags.ovf) |-> rd_flags.valid);

endmodule

// File: rtl/hit_ts_buffer.sv
module hit_ts_buffer
    import hbuf_pkg::*;
#(
    parameter int unsigned NUM_PIX     = DEF_NUM_PIX,
    parameter int unsigned TS_W        = DEF_TS_W,
    parameter int unsigned SUB_W       = DEF_SUB_W,
    parameter int unsigned TRAIN_XINGS = DEF_TRAIN_XINGS,
    parameter int unsigned PIX_AW      = (NUM_PIX > 1) ? $clog2(NUM_PIX) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               train_start,
    input  logic [NUM_PIX-1:0] hit,
    output logic               train_active,
    input  logic               rd_en,
    input  logic [PIX_AW-1:0]  rd_pix,
    input  logic [SUB_W-1:0]   rd_sub,
    output logic               rd_vld,
    output logic               rd_slot_valid,
    output logic               rd_ovf,
    output logic [TS_W-1:0]    rd_ts
);

    logic [TS_W-1:0]                stamp;
    logic [SUB_W-1:0]               sub_idx;
    logic [NUM_PIX-1:0]             accept;
    slot_flags_t [NUM_PIX-1:0]      pix_flags;
    logic [NUM_PIX-1:0][TS_W-1:0]   pix_ts;
    slot_flags_t                    out_flags;

    hbuf_xing_ctr #(
        .TS_W        (TS_W),
        .SUB_W       (SUB_W),
        .TRAIN_XINGS (TRAIN_XINGS)
    ) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .start   (train_start),
        .active  (train_active),
        .stamp   (stamp),
        .sub_idx (sub_idx)
    );

    // A hit counts only inside the train and never on the start pulse.
    assign accept = hit & {NUM_PIX{train_active && !train_start}};

    generate
        for (genvar p = 0; p < NUM_PIX; p++) begin : g_pix
            hbuf_pixel #(
                .TS_W  (TS_W),
                .SUB_W (SUB_W)
            ) u_pix (
                .clk      (clk),
                .rst      (rst),
                .clear    (train_start),
                .accept   (accept[p]),
                .sub_idx  (sub_idx),
                .stamp    (stamp),
                .rd_sub   (rd_sub),
                .rd_flags (pix_flags[p]),
                .rd_ts    (pix_ts[p])
            );
        end
    endgenerate

    hbuf_readout #(
        .TS_W    (TS_W),
        .NUM_PIX (NUM_PIX),
        .PIX_AW  (PIX_AW)
    ) u_rd (
        .clk       (clk),
        .rst       (rst),
        .rd_en     (rd_en),
        .rd_pix    (rd_pix),
        .pix_flags (pix_flags),
        .pix_ts    (pix_ts),
        .rd_vld    (rd_vld),
        .rd_flags  (out_flags),
        .rd_ts     (rd_ts)
    );

    assign rd_slot_valid = out_flags.valid;
    assign rd_ovf        = out_flags.ovf;

endmodule

// File: tb/sim_hit_ts_buffer.sv
module sim_hit_ts_buffer;

    localparam int NP    = 4;
    localparam int TSW   = 8;
    localparam int SW    = 4;
    localparam int NS    = 1 << SW;
    localparam int SLEN  = 1 << (TSW - SW);
    localparam int TRAIN = 200;   // last subtrain (12) is partial

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            train_start = 1'b0;
    logic [NP-1:0]   hit = '0;
    logic            train_active;
    logic            rd_en = 1'b0;
    logic [1:0]      rd_pix = '0;
    logic [SW-1:0]   rd_sub = '0;
    logic            rd_vld, rd_slot_valid, rd_ovf;
    logic [TSW-1:0]  rd_ts;

    int checks = 0;
    int errors = 0;

    bit exp_v [NP][NS];
    bit exp_o [NP][NS];
    int exp_t [NP][NS];

    always #2.5 clk = ~clk;

    hit_ts_buffer #(
        .NUM_PIX(NP), .TS_W(TSW), .SUB_W(SW), .TRAIN_XINGS(TRAIN)
    ) u0 (
        .clk(clk), .rst(rst), .train_start(train_start), .hit(hit),
        .train_active(train_active), .rd_en(rd_en), .rd_pix(rd_pix),
        .rd_sub(rd_sub), .rd_vld(rd_vld), .rd_slot_valid(rd_slot_valid),
        .rd_ovf(rd_ovf), .rd_ts(rd_ts)
    );

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", what, act, exp);
        end
    endtask

    function automatic bit pat(input int trial, input int p, input int x);
        case (trial)
            0: return (x % SLEN) == ((p + x / SLEN) % SLEN);
            1: return (x % SLEN) == p || (x % SLEN) == p + 5 || (p == 2 && (x % SLEN) == 15);
            2: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic clear_model();
        for (int p = 0; p < NP; p++)
            for (int s = 0; s < NS; s++) begin
                exp_v[p][s] = 0; exp_o[p][s] = 0; exp_t[p][s] = 0;
            end
    endtask

    task automatic run_train(input int trial);
        clear_model();
        // R7: hits before the start pulse are ignored
        @(negedge clk); hit = '1;
        repeat (3) @(posedge clk);
        // R2: hits during the pulse cycle are ignored
        @(negedge clk); train_start = 1'b1; hit = '1;
        @(posedge clk); #1;
        chk(train_active == 1'b1, "R2 train_active after start", int'(train_active), 1);
        for (int x = 0; x < TRAIN; x++) begin
            @(negedge clk);
            train_start = 1'b0;
            for (int p = 0; p < NP; p++) begin
                hit[p] = pat(trial, p, x);
                if (hit[p]) begin
                    if (!exp_v[p][x / SLEN]) begin
                        exp_v[p][x / SLEN] = 1; exp_t[p][x / SLEN] = x;
                    end else begin
                        exp_o[p][x / SLEN] = 1;
                    end
                end
            end
            @(posedge clk);
            if (x == TRAIN - 2) begin
                #1;
                chk(train_active == 1'b1, "R3 active before last crossing", int'(train_active), 1);
            end
        end
        #1;
        chk(train_active == 1'b0, "R3 inactive after last crossing", int'(train_active), 0);
        // R7: hits after the train are ignored
        @(negedge clk); hit = '1;
        repeat (5) @(posedge clk);
        @(negedge clk); hit = '0;
    endtask

    task automatic sweep(input string tag);
        for (int p = 0; p < NP; p++)
            for (int s = 0; s < NS; s++) begin
                @(negedge clk);
                rd_en = 1'b1; rd_pix = 2'(p); rd_sub = SW'(s);
                @(posedge clk); #1;
                chk(rd_vld == 1'b1, $sformatf("R8 rd_vld pix %0d sub %0d", p, s), int'(rd_vld), 1);
                chk(rd_slot_valid == exp_v[p][s], $sformatf("%s valid pix %0d sub %0d", tag, p, s),
                    int'(rd_slot_valid), int'(exp_v[p][s]));
                chk(rd_ovf == exp_o[p][s], $sformatf("%s ovf pix %0d sub %0d", tag, p, s),
                    int'(rd_ovf), int'(exp_o[p][s]));
                if (exp_v[p][s])
                    chk(int'(rd_ts) == exp_t[p][s], $sformatf("%s ts pix %0d sub %0d", tag, p, s),
                        int'(rd_ts), exp_t[p][s]);
            end
        @(negedge clk); rd_en = 1'b0;
        @(posedge clk); #1;
        chk(rd_vld == 1'b0, "R8 rd_vld low without request", int'(rd_vld), 0);
    endtask

    initial begin
        #2_000_000;
        errors++; checks++;
        $display("FAIL R1 watchdog expired actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        chk(train_active == 1'b0, "R1 train_active after reset", int'(train_active), 0);
        chk(rd_vld == 1'b0, "R1 rd_vld after reset", int'(rd_vld), 0);
        clear_model();
        sweep("R1");
        run_train(0); sweep("R4 R7");
        run_train(1); sweep("R5");
        run_train(2); sweep("R6");
        run_train(3); sweep("R2");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule